// File: doc/BRIEF.md
# Page Write Sequencer

This block sits behind the serial-bus slave of a small serial memory. During a write command it is handed the target word address, then each data byte as the bus receiver finishes it. The bytes wait in a page buffer whose depth is a parameter (2 or 8). When the master ends the transfer with STOP, the block runs a self-timed program cycle. The cycle issues one array write per buffered byte, in the order the bytes arrived, at consecutive addresses from the given word address.

Every byte takes a fixed number of system clocks, set by a parameter, so the whole cycle grows with the number of bytes. A write that carries more bytes than the buffer can hold is cancelled in full. While the cycle runs, the busy output is high. The bus slave uses it to hold back its acknowledge, and the sequencer itself ignores new commands until busy clears. The address counter wraps inside a 256-byte block and keeps the block-select bits that sit above it.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, and after a reset that interrupts a program cycle, `busy_o` and `arr_we_o` are low, the buffer is empty, and a later STOP with no new data writes nothing.
- R2: Buffered bytes are written in arrival order: write k (k = 0..N-1) carries the k-th received byte.
- R3: A program cycle starts only on a STOP that follows 1 to PAGE_BYTES data bytes. A STOP with no data byte after the address load starts no cycle and writes nothing.
- R4: If more than PAGE_BYTES data bytes arrive, the STOP starts no cycle, `busy_o` stays low and no array write is issued.
- R5: `busy_o` rises on the clock edge that samples STOP. Write k (k = 1..N) is seen k*TICK_CYCLES cycles after busy rises. Busy stays high for N*TICK_CYCLES+1 cycles and falls one clock after the last write.
- R6: Write k goes to the address whose low BLK_W bits are (start low bits + k) modulo 2^BLK_W and whose upper bits equal the upper bits of the start address.
- R7: While `busy_o` is high, address loads, data bytes and STOP strobes have no effect. After the cycle the buffer is empty, so a lone STOP writes nothing.
- R8: `arr_we_o` is high only while `busy_o` is high, for one cycle per written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Strobe: a write command's word address is present |
| addr_i | input | ADDR_W | Start address (block bits above BLK_W word bits) |
| byte_vld_i | input | 1 | Strobe: one received data byte is present |
| byte_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Strobe: STOP seen on the bus |
| arr_we_o | output | 1 | Array write strobe, one cycle per byte |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Program cycle in progress |

## Verification
Busy is registered, so it is first seen high in the cycle after the edge that takes STOP. The k-th write strobe follows exactly k*TICK_CYCLES cycles later, and busy is gone one cycle after the last strobe. The bench drives and samples on the falling edge and stamps every observed write and busy rise with a cycle counter. It then compares these stamps with the exact offsets. Cases that must produce no activity, such as overflow, an empty STOP and strobes during busy, are waited out for longer than a full cycle would take before the write log is checked.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_FIN  = 2'd2
    } pgwr_state_e;

endpackage

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DEPTH-1:0]             slot_we;
    logic [DEPTH-1:0][DATA_W-1:0] slot_q;

    always_comb begin
        ctl_d   = ctl_q;
        slot_we = '0;
        if (clr_i) begin
            ctl_d.cnt = '0;
            ctl_d.ovf = 1'b0;
        end else if (wr_i && !ctl_q.ovf) begin
            if (ctl_q.cnt == CNT_W'(DEPTH)) begin
                ctl_d.ovf = 1'b1;
            end else begin
                slot_we[ctl_q.cnt[IDX_W-1:0]] = 1'b1;
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          slot_q[g] <= '0;
            else if (slot_we[g]) slot_q[g] <= wdata_i;
        end
    end

    assign count_o = ctl_q.cnt;
    assign ovf_o   = ctl_q.ovf;
    assign rdata_o = slot_q[rd_idx_i];

endmodule

// File: rtl/pgwr_tick.sv
module pgwr_tick #(
    parameter int TICK_CYCLES = 1000,
    localparam int TW = $clog2(TICK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic done_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    assign done_o = en_i && (cnt_q == TW'(TICK_CYCLES - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || done_o) cnt_d = '0;
        else                 cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES  = 2,
    parameter int TICK_CYCLES = 1000,
    parameter int ADDR_W      = 9,
    parameter int BLK_W       = 8,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o,
    output logic              busy_o
);

    localparam int CNT_W = $clog2(PAGE_BYTES + 1);
    localparam int IDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

    typedef struct packed {
        pgwr_state_e       st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t s_d, s_q;

    logic              buf_clr, buf_wr, buf_ovf;
    logic [CNT_W-1:0]  buf_cnt;
    logic [DATA_W-1:0] buf_rdata;
    logic              tick_en, tick_done;
    logic [BLK_W-1:0]  lo_addr;

    pgwr_buf #(
        .DEPTH  (PAGE_BYTES),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (buf_clr),
        .wr_i     (buf_wr),
        .wdata_i  (byte_i),
        .rd_idx_i (s_q.idx),
        .count_o  (buf_cnt),
        .ovf_o    (buf_ovf),
        .rdata_o  (buf_rdata)
    );

    pgwr_tick #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .done_o (tick_done)
    );

    assign lo_addr = s_q.base[BLK_W-1:0] + BLK_W'(s_q.idx);

    always_comb begin
        s_d     = s_q;
        s_d.we  = 1'b0;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        tick_en = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (addr_load_i) begin
                    s_d.base = addr_i;
                    buf_clr  = 1'b1;
                end else begin
                    buf_wr = byte_vld_i;
                    if (stop_i) begin
                        if (buf_cnt != '0 && !buf_ovf) begin
                            s_d.st  = ST_PROG;
                            s_d.idx = '0;
                        end else begin
                            buf_clr = 1'b1;
                        end
                    end
                end
            end
            ST_PROG: begin
                tick_en = 1'b1;
                if (tick_done) begin
                    s_d.we    = 1'b1;
                    s_d.waddr = {s_q.base[ADDR_W-1:BLK_W], lo_addr};
                    s_d.wdata = buf_rdata;
                    s_d.idx   = s_q.idx + IDX_W'(1);
                    if (CNT_W'(s_q.idx) == buf_cnt - CNT_W'(1)) s_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                buf_clr = 1'b1;
                s_d.st  = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign arr_we_o   = s_q.we;
    assign arr_addr_o = s_q.waddr;
    assign arr_data_o = s_q.wdata;
    assign busy_o     = (s_q.st != ST_IDLE);

endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk #(
    parameter int ADDR_W = 9,
    parameter int BLK_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              stop_i,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic              busy_o
);

    logic [ADDR_W-BLK_W-1:0] blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       blk_q <= '0;
        else if (addr_load_i && !busy_o)  blk_q <= addr_i[ADDR_W-1:BLK_W];
    end

    p_we_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    p_fall_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(arr_we_o));

    p_rise_no_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !arr_we_o);

    p_rise_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    p_block_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> (arr_addr_o[ADDR_W-1:BLK_W] == blk_q));

endmodule

bind pgwr_seq pgwr_seq_chk #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_load_i (addr_load_i),
    .addr_i      (addr_i),
    .stop_i      (stop_i),
    .arr_we_o    (arr_we_o),
    .arr_addr_o  (arr_addr_o),
    .busy_o      (busy_o)
);

// File: tb/pgwr_seq_test.sv
module pgwr_seq_test;

    localparam int CLK_P = 10;
    localparam int PAGE  = 8;
    localparam int TICK  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [8:0] addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] bdat = '0;
    logic       stop = 1'b0;
    logic       arr_we;
    logic [8:0] arr_addr;
    logic [7:0] arr_data;
    logic       busy;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pgwr_seq #(
        .PAGE_BYTES  (PAGE),
        .TICK_CYCLES (TICK),
        .ADDR_W      (9),
        .BLK_W       (8),
        .DATA_W      (8)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_load_i (addr_load),
        .addr_i      (addr),
        .byte_vld_i  (byte_vld),
        .byte_i      (bdat),
        .stop_i      (stop),
        .arr_we_o    (arr_we),
        .arr_addr_o  (arr_addr),
        .arr_data_o  (arr_data),
        .busy_o      (busy)
    );

    // monitor: falling-edge sampling with cycle stamps
    int         cyc = 0;
    int         busy_cnt = 0;
    int         rise_cyc = 0;
    logic       busy_prev = 1'b0;
    int         wlog_n = 0;
    logic [8:0] wlog_a [64];
    logic [7:0] wlog_d [64];
    int         wlog_c [64];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (busy) busy_cnt = busy_cnt + 1;
        if (busy && !busy_prev) rise_cyc = cyc;
        busy_prev = busy;
        if (arr_we && wlog_n < 64) begin
            wlog_a[wlog_n] = arr_addr;
            wlog_d[wlog_n] = arr_data;
            wlog_c[wlog_n] = cyc;
            wlog_n = wlog_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [8:0] a);
        @(negedge clk); addr_load = 1'b1; addr = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); byte_vld = 1'b1; bdat = d;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    // vector: [20:12] start address, [11:8] byte count, [7:0] first data value
    localparam logic [20:0] VEC [7] = '{
        {9'h010, 4'd1, 8'hA0},
        {9'h020, 4'd2, 8'h11},
        {9'h140, 4'd8, 8'h30},
        {9'h1FD, 4'd5, 8'h55},
        {9'h050, 4'd9, 8'h77},
        {9'h060, 4'd0, 8'h00},
        {9'h0FF, 4'd3, 8'hC0}
    };

    initial begin
        #(CLK_P * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(arr_we == 1'b0, "R1 we in reset", int'(arr_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < 7; v++) begin
            logic [8:0] a;
            int n, db, w0, b0, expn;
            a  = VEC[v][20:12];
            n  = int'(VEC[v][11:8]);
            db = int'(VEC[v][7:0]);
            w0 = wlog_n;
            b0 = busy_cnt;
            do_load(a);
            for (int i = 0; i < n; i++) do_byte(8'(db + i));
            do_stop();
            repeat (n * TICK + 6) @(negedge clk);
            expn = (n >= 1 && n <= PAGE) ? n : 0;
            chk(wlog_n - w0 == expn, (n > PAGE) ? "R4 write count" : "R3 write count",
                wlog_n - w0, expn);
            for (int k = 0; k < expn; k++) begin
                logic [8:0] ea;
                ea = {a[8], 8'(a[7:0] + 8'(k))};
                chk(wlog_a[w0+k] == ea, "R6 address", int'(wlog_a[w0+k]), int'(ea));
                chk(wlog_d[w0+k] == 8'(db + k), "R2 data order", int'(wlog_d[w0+k]), db + k);
                chk(wlog_c[w0+k] == rise_cyc + (k + 1) * TICK, "R5 write timing",
                    wlog_c[w0+k] - rise_cyc, (k + 1) * TICK);
            end
            chk(busy_cnt - b0 == ((expn > 0) ? expn * TICK + 1 : 0), "R5 busy length",
                busy_cnt - b0, (expn > 0) ? expn * TICK + 1 : 0);
            chk(busy == 1'b0, "R5 busy cleared", int'(busy), 0);
        end

        // R7: strobes during busy are ignored
        begin
            int w0, b0;
            w0 = wlog_n;
            b0 = busy_cnt;
            do_load(9'h080);
            do_byte(8'hE1);
            do_byte(8'hE2);
            do_stop();
            @(negedge clk);
            chk(busy == 1'b1, "R7 busy during cycle", int'(busy), 1);
            do_load(9'h090);
            do_byte(8'h99);
            do_stop();
            repeat (2 * TICK + 8) @(negedge clk);
            chk(wlog_n - w0 == 2, "R7 write count", wlog_n - w0, 2);
            chk(wlog_a[w0+1] == 9'h081, "R7 address", int'(wlog_a[w0+1]), 9'h081);
            chk(wlog_d[w0+1] == 8'hE2, "R7 data", int'(wlog_d[w0+1]), 8'hE2);
            chk(busy_cnt - b0 == 2 * TICK + 1, "R7 busy length", busy_cnt - b0, 2 * TICK + 1);
            // buffer is empty after the cycle: lone STOP writes nothing
            w0 = wlog_n;
            do_stop();
            repeat (TICK + 6) @(negedge clk);
            chk(wlog_n - w0 == 0, "R7 lone stop", wlog_n - w0, 0);
        end

        // R3: STOP right after the address load
        begin
            int w0, b0;
            w0 = wlog_n;
            b0 = busy_cnt;
            do_load(9'h033);
            do_stop();
            repeat (TICK + 6) @(negedge clk);
            chk(wlog_n - w0 == 0 && busy_cnt == b0, "R3 empty stop", wlog_n - w0, 0);
        end

        // R1: reset during a program cycle
        begin
            int w0;
            do_load(9'h0A0);
            do_byte(8'h5A);
            do_byte(8'h5B);
            do_stop();
            @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
            chk(arr_we == 1'b0, "R1 we after reset", int'(arr_we), 0);
            rst_n = 1'b1;
            w0 = wlog_n;
            do_stop();
            repeat (2 * TICK + 6) @(negedge clk);
            chk(wlog_n - w0 == 0, "R1 buffer cleared", wlog_n - w0, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule